// File: doc/BRIEF.md
# Instruction Cycle Sequencer for a 16-bit Accumulator Machine

This block steps a small accumulator machine through each instruction. A timing counter walks through steps T0 to T6. In these steps the block fetches a word from a 4096-word store, decodes a three-bit opcode into eight one-hot lines, and resolves an optional indirect address. It then carries out one of seven instructions that address memory: logical AND, add, load, store, unconditional branch, subroutine call, and increment-and-skip-if-zero.

The block holds the program counter, the address register, the instruction register, a data register and the indirect flag. It does not hold the accumulator. For AND, add and load it issues a one-cycle update request that carries an operation code and the operand, and the accumulator logic outside the block applies it. For a store it takes the accumulator value on an input.

Opcode 7 marks a register-reference or I/O instruction. For this opcode the block raises a one-cycle strobe at T3 that hands the indirect bit and the 12-bit field to outside executors, and then returns to T0.

The store reads synchronously: data appears one cycle after the address. Every step that reads therefore lasts two cycles. In the first cycle the block issues the read, and in the second it captures the data. Every other step lasts one cycle.

Top module: `instr_seq`

## Requirements
- R1: While the synchronous active-high reset is held, the outputs show PC 0 and step 0, and no write, accumulator request or dispatch strobe is raised.
- R2: Each instruction starts in step 0. The word at address PC is fetched as the instruction, and PC advances by one.
- R3: During T3, the decode lines are one-hot with bit n set, where n is instruction bits 14..12.
- R4: When bit 15 is 1 and the opcode is not 7, the effective address is the low 12 bits of the word stored at address bits 11..0. Otherwise the effective address is bits 11..0.
- R5: Opcodes 0, 1 and 2 read the operand from the effective address. At T5 they raise acu_req for one cycle, with acu_op 0 (AND), 1 (ADD with carry to the link bit) or 2 (LOAD) and the operand on acu_opnd.
- R6: Opcode 3 writes ac_in to the effective address. A write happens only in step 4 or step 6.
- R7: Opcode 4 sets PC to the effective address.
- R8: Opcode 5 writes the return PC, zero-extended, to the effective address and sets PC to the effective address plus one.
- R9: Opcode 6 writes the stored word plus one back to the effective address. If the result is zero, PC advances by one more.
- R10: Opcode 7 gives exactly one disp_valid cycle at T3, carrying bit 15 and bits 11..0, and the next step is 0. No other opcode raises disp_valid.
- R11: Each read step lasts two cycles, and no read is issued two cycles in a row. An instruction takes 4 cycles of fetch, plus 1 cycle at T3 (2 if indirect), plus 3 cycles for opcodes 0 to 2, 1 for opcodes 3 and 4, 2 for opcode 5 and 4 for opcode 6. Opcode 7 ends after T3.
- R12: Read and write are never raised together, and the step never exceeds 6.
- R13: PC does not change as a result of step 0, 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Store address (address register) |
| mem_rd | output | 1 | Read request; data is expected on the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after mem_rd |
| ac_in | input | 16 | Accumulator value for the store instruction |
| acu_req | output | 1 | Accumulator update request |
| acu_op | output | 2 | Update kind: 0 AND, 1 ADD, 2 LOAD |
| acu_opnd | output | 16 | Operand for the update |
| disp_valid | output | 1 | Dispatch strobe for opcode 7 |
| disp_ind | output | 1 | Bit 15 of the dispatched instruction |
| disp_field | output | 12 | Bits 11..0 of the dispatched instruction |
| dec_o | output | 8 | One-hot opcode decode lines |
| pc_o | output | 12 | Program counter |
| step_o | output | 3 | Timing step |

## Verification
The assertions check these properties on every cycle:
- read and write are never raised together;
- the step stays at or below 6, and PC holds through steps 0, 2 and 3;
- a write appears only in step 4 or 6;
- reads are never issued back to back;
- every accumulator request comes two cycles after a read;
- a dispatch strobe is followed by step 0.

Only the bench scenarios can show that the architectural results are right. The bench compares each instruction against an instruction-level model, checking effective addresses through indirection, the skip after an increment wraps to zero, the return address that the subroutine call stores, and the cycle count of each instruction.

// File: rtl/seq_pkg.sv
package seq_pkg;
   typedef enum logic [1:0] {
      ACU_AND  = 2'd0,
      ACU_ADD  = 2'd1,
      ACU_LOAD = 2'd2
   } acu_op_t;

   localparam int NSTEP = 7;
   localparam int OP_AND = 0;
   localparam int OP_ADD = 1;
   localparam int OP_LDA = 2;
   localparam int OP_STA = 3;
   localparam int OP_BUN = 4;
   localparam int OP_BSA = 5;
   localparam int OP_ISZ = 6;
   localparam int OP_EXT = 7;
endpackage

// File: rtl/seq_step_ctr.sv
module seq_step_ctr #(
   parameter int SW = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          two_cyc,
   input  logic          fin,
   output logic [SW-1:0] step,
   output logic          ph
);
   always_ff @(posedge clk) begin
      if (rst) begin
         step <= '0;
         ph   <= 1'b0;
      end else if (two_cyc && !ph) begin
         ph <= 1'b1;
      end else begin
         ph   <= 1'b0;
         step <= fin ? '0 : step + 1'b1;
      end
   end
endmodule

// File: rtl/seq_op_decode.sv
module seq_op_decode #(
   parameter int OPW = 3,
   localparam int NDEC = 1 << OPW
) (
   input  logic [OPW-1:0]  op,
   output logic [NDEC-1:0] lines
);
   for (genvar g = 0; g < NDEC; g++) begin : g_line
      assign lines[g] = (op == OPW'(g));
   end
endmodule

// File: rtl/instr_seq.sv
module instr_seq
   import seq_pkg::*;
#(
   parameter int AW  = 12,
   parameter int DW  = 16,
   parameter int OPW = 3,
   parameter int SW  = 3
) (
   input  logic                clk,
   input  logic                rst,
   output logic [AW-1:0]       mem_addr,
   output logic                mem_rd,
   output logic                mem_wr,
   output logic [DW-1:0]       mem_wdata,
   input  logic [DW-1:0]       mem_rdata,
   input  logic [DW-1:0]       ac_in,
   output logic                acu_req,
   output logic [1:0]          acu_op,
   output logic [DW-1:0]       acu_opnd,
   output logic                disp_valid,
   output logic                disp_ind,
   output logic [AW-1:0]       disp_field,
   output logic [(1<<OPW)-1:0] dec_o,
   output logic [AW-1:0]       pc_o,
   output logic [SW-1:0]       step_o
);
   localparam int NDEC  = 1 << OPW;
   localparam int PADW  = DW - AW;
   localparam int OPLSB = DW - 1 - OPW;

   if (DW < AW + OPW + 1) begin : g_bad_width
      $error("instr_seq: data width cannot hold flag, opcode and address");
   end
   if (OPW != 3) begin : g_bad_opw
      $error("instr_seq: opcode field must be three bits");
   end
   if ((1 << SW) < NSTEP) begin : g_bad_sw
      $error("instr_seq: step counter too narrow");
   end

   logic [AW-1:0]    pc_q, ar_q;
   logic [DW-1:0]    ir_q, dr_q;
   logic             ind_q;
   logic [SW-1:0]    step;
   logic             ph;
   logic [NDEC-1:0]  dl;
   logic [NSTEP-1:0] ts;
   logic             mref_rd, rd_step, fin, cap;

   seq_op_decode #(.OPW(OPW)) u_dec (
      .op    (ir_q[OPLSB +: OPW]),
      .lines (dl)
   );

   for (genvar k = 0; k < NSTEP; k++) begin : g_ts
      assign ts[k] = (step == SW'(k));
   end

   assign mref_rd = dl[OP_AND] | dl[OP_ADD] | dl[OP_LDA] | dl[OP_ISZ];
   assign rd_step = ts[1] | (ts[3] & ~dl[OP_EXT] & ind_q) | (ts[4] & mref_rd);
   assign fin     = (ts[3] & dl[OP_EXT])
                  | (ts[4] & (dl[OP_STA] | dl[OP_BUN]))
                  | (ts[5] & (dl[OP_AND] | dl[OP_ADD] | dl[OP_LDA] | dl[OP_BSA]))
                  | ts[6];
   assign cap     = rd_step & ph;

   seq_step_ctr #(.SW(SW)) u_ctr (
      .clk     (clk),
      .rst     (rst),
      .two_cyc (rd_step),
      .fin     (fin),
      .step    (step),
      .ph      (ph)
   );

   assign mem_addr = ar_q;
   assign mem_rd   = rd_step & ~ph;
   assign mem_wr   = (ts[4] & (dl[OP_STA] | dl[OP_BSA])) | (ts[6] & dl[OP_ISZ]);

   always_comb begin
      if (dl[OP_STA])      mem_wdata = ac_in;
      else if (dl[OP_BSA]) mem_wdata = {{PADW{1'b0}}, pc_q};
      else                 mem_wdata = dr_q;
   end

   assign acu_req  = ts[5] & (dl[OP_AND] | dl[OP_ADD] | dl[OP_LDA]);
   assign acu_op   = dl[OP_ADD] ? ACU_ADD : (dl[OP_LDA] ? ACU_LOAD : ACU_AND);
   assign acu_opnd = dr_q;

   assign disp_valid = ts[3] & dl[OP_EXT];
   assign disp_ind   = ind_q;
   assign disp_field = ir_q[AW-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q  <= '0;
         ar_q  <= '0;
         ir_q  <= '0;
         dr_q  <= '0;
         ind_q <= 1'b0;
      end else begin
         if (ts[0]) ar_q <= pc_q;
         if (ts[1] && ph) begin
            ir_q <= mem_rdata;
            pc_q <= pc_q + 1'b1;
         end
         if (ts[2]) begin
            ar_q  <= ir_q[AW-1:0];
            ind_q <= ir_q[DW-1];
         end
         if (ts[3] && cap) ar_q <= mem_rdata[AW-1:0];
         if (ts[4]) begin
            if (cap)        dr_q <= mem_rdata;
            if (dl[OP_BUN]) pc_q <= ar_q;
            if (dl[OP_BSA]) ar_q <= ar_q + 1'b1;
         end
         if (ts[5]) begin
            if (dl[OP_BSA]) pc_q <= ar_q;
            if (dl[OP_ISZ]) dr_q <= dr_q + 1'b1;
         end
         if (ts[6] && dr_q == '0) pc_q <= pc_q + 1'b1;
      end
   end

   assign dec_o  = dl;
   assign pc_o   = pc_q;
   assign step_o = step;
endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
   parameter int AW = 12,
   parameter int SW = 3
) (
   input logic          clk,
   input logic          rst,
   input logic          mem_rd,
   input logic          mem_wr,
   input logic          acu_req,
   input logic          disp_valid,
   input logic [AW-1:0] pc_o,
   input logic [SW-1:0] step_o
);
   assert_rdwr_excl_R12: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_wr));

   assert_step_bound_R12: assert property (@(posedge clk) disable iff (rst)
      step_o <= SW'(6));

   assert_pc_hold_R13: assert property (@(posedge clk) disable iff (rst)
      (step_o == SW'(0) || step_o == SW'(2) || step_o == SW'(3)) |=> $stable(pc_o));

   assert_wr_step_R6: assert property (@(posedge clk) disable iff (rst)
      mem_wr |-> (step_o == SW'(4) || step_o == SW'(6)));

   assert_rd_gap_R11: assert property (@(posedge clk) disable iff (rst)
      mem_rd |=> !mem_rd);

   assert_acu_after_read_R5: assert property (@(posedge clk) disable iff (rst)
      acu_req |-> $past(mem_rd, 2));

   assert_disp_end_R10: assert property (@(posedge clk) disable iff (rst)
      disp_valid |=> (!disp_valid && step_o == SW'(0)));
endmodule

bind instr_seq seq_chk #(.AW(AW), .SW(SW)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .mem_rd     (mem_rd),
   .mem_wr     (mem_wr),
   .acu_req    (acu_req),
   .disp_valid (disp_valid),
   .pc_o       (pc_o),
   .step_o     (step_o)
);

// File: tb/sim_instr_seq.sv
`timescale 1ns/1ps
module sim_instr_seq;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [11:0] mem_addr;
   logic        mem_rd, mem_wr;
   logic [15:0] mem_wdata, mem_rdata, ac_in;
   logic        acu_req;
   logic [1:0]  acu_op;
   logic [15:0] acu_opnd;
   logic        disp_valid, disp_ind;
   logic [11:0] disp_field;
   logic [7:0]  dec_o;
   logic [11:0] pc_o;
   logic [2:0]  step_o;

   instr_seq u0 (
      .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ac_in(ac_in),
      .acu_req(acu_req), .acu_op(acu_op), .acu_opnd(acu_opnd),
      .disp_valid(disp_valid), .disp_ind(disp_ind), .disp_field(disp_field),
      .dec_o(dec_o), .pc_o(pc_o), .step_o(step_o)
   );

   always #10 clk = ~clk;

   logic [15:0] mem [4096];
   logic [15:0] mdl [4096];
   logic [15:0] ac_env;
   logic        e_env;
   int checks = 0;
   int fails  = 0;
   int wd     = 0;

   always @(posedge clk) begin
      if (mem_wr) mem[mem_addr] <= mem_wdata;
      if (mem_rd) mem_rdata <= mem[mem_addr];
   end

   always @(posedge clk) begin
      if (rst) begin
         ac_env <= '0;
         e_env  <= 1'b0;
      end else if (acu_req) begin
         case (acu_op)
            2'd0: ac_env <= ac_env & acu_opnd;
            2'd1: {e_env, ac_env} <= {1'b0, ac_env} + {1'b0, acu_opnd};
            default: ac_env <= acu_opnd;
         endcase
      end
   end
   assign ac_in = ac_env;

   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", wd);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   logic [11:0] m_pc, m_ea, m_fld;
   logic [15:0] m_ac;
   logic        m_e, m_ind;
   logic [2:0]  m_op;

   function automatic int exp_cycles(input logic [2:0] op, input logic ind);
      int c = 5;
      if (op == 3'd7) return c;
      if (ind) c = c + 1;
      case (op)
         3'd0, 3'd1, 3'd2: c = c + 3;
         3'd3, 3'd4:       c = c + 1;
         3'd5:             c = c + 2;
         default:          c = c + 4;
      endcase
      return c;
   endfunction

   function automatic string op_tag(input logic [2:0] op);
      case (op)
         3'd3: return "R6";
         3'd4: return "R7";
         3'd5: return "R8";
         3'd6: return "R9";
         3'd7: return "R10";
         default: return "R5";
      endcase
   endfunction

   task automatic model_exec();
      logic [15:0] ir, w;
      logic [16:0] s;
      ir    = mdl[m_pc];
      m_pc  = m_pc + 12'd1;
      m_op  = ir[14:12];
      m_ind = ir[15];
      m_ea  = ir[11:0];
      m_fld = ir[11:0];
      if (m_op != 3'd7) begin
         if (m_ind) m_ea = mdl[m_ea][11:0];
         case (m_op)
            3'd0: m_ac = m_ac & mdl[m_ea];
            3'd1: begin
               s = {1'b0, m_ac} + {1'b0, mdl[m_ea]};
               m_ac = s[15:0];
               m_e  = s[16];
            end
            3'd2: m_ac = mdl[m_ea];
            3'd3: mdl[m_ea] = m_ac;
            3'd4: m_pc = m_ea;
            3'd5: begin
               mdl[m_ea] = {4'h0, m_pc};
               m_pc = m_ea + 12'd1;
            end
            default: begin
               w = mdl[m_ea] + 16'd1;
               mdl[m_ea] = w;
               if (w == 16'd0) m_pc = m_pc + 12'd1;
            end
         endcase
      end
   endtask

   task automatic run_one();
      int cyc = 0;
      int ndisp = 0;
      bit rw_bad = 0;
      bit dec_bad = 0;
      logic d_ind = 0;
      logic [11:0] d_fld = '0;
      string et;
      model_exec();
      forever begin
         if (mem_rd && mem_wr) rw_bad = 1;
         if (disp_valid) begin
            ndisp++;
            d_ind = disp_ind;
            d_fld = disp_field;
         end
         if (step_o == 3'd3 && dec_o != (8'd1 << m_op)) dec_bad = 1;
         @(negedge clk);
         cyc++;
         if (step_o == 3'd0 || cyc > 30) break;
      end
      et = (m_ind && m_op != 3'd7) ? "R4" : op_tag(m_op);
      chk(!dec_bad, "R3", "decode lines", {24'd0, dec_o}, 32'd1 << m_op);
      chk(!rw_bad, "R12", "read with write", 32'(rw_bad), 32'd0);
      chk(cyc == exp_cycles(m_op, m_ind), "R11", "cycle count", 32'(cyc),
          32'(exp_cycles(m_op, m_ind)));
      chk(pc_o == m_pc, (m_op >= 3'd4 && m_op <= 3'd6) ? op_tag(m_op) : "R2", "pc",
          {20'd0, pc_o}, {20'd0, m_pc});
      chk(ac_env == m_ac && e_env == m_e, et, "ac/e", {15'd0, e_env, ac_env},
          {15'd0, m_e, m_ac});
      if (m_op == 3'd7) begin
         chk(ndisp == 1 && d_ind == m_ind && d_fld == m_fld, "R10", "dispatch",
             {19'd0, d_ind, d_fld}, {19'd0, m_ind, m_fld});
      end else begin
         chk(ndisp == 0, "R10", "no dispatch", 32'(ndisp), 32'd0);
         chk(mem[m_ea] == mdl[m_ea], et, "memory word", {16'd0, mem[m_ea]},
             {16'd0, mdl[m_ea]});
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      m_pc = '0;
      m_ac = '0;
      m_e  = 1'b0;
      repeat (3) @(negedge clk);
      chk(pc_o == 12'd0 && step_o == 3'd0, "R1", "reset pc/step",
          {17'd0, step_o, pc_o}, 32'd0);
      chk(!mem_wr && !acu_req && !disp_valid, "R1", "reset strobes",
          {29'd0, mem_wr, acu_req, disp_valid}, 32'd0);
      rst = 1'b0;
   endtask

   task automatic put(input logic [11:0] a, input logic [15:0] d);
      mem[a] = d;
      mdl[a] = d;
   endtask

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < 4096; i++) put(12'(i), 16'd0);
      put(12'h000, 16'h2100);
      put(12'h001, 16'h1101);
      put(12'h002, 16'h6102);
      put(12'h003, 16'h7000);
      put(12'h004, 16'h5200);
      put(12'h201, 16'h7ABC);
      put(12'h202, 16'hB103);
      put(12'h203, 16'h8105);
      put(12'h204, 16'hC106);
      put(12'h100, 16'hFFFF);
      put(12'h101, 16'h0001);
      put(12'h102, 16'hFFFF);
      put(12'h103, 16'h0104);
      put(12'h105, 16'h0107);
      put(12'h107, 16'h1234);
      put(12'h106, 16'h0300);
      put(12'h300, 16'hF5A5);
      do_reset();
      for (int n = 0; n < 9; n++) run_one();

      rst = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 4096; i++) put(12'(i), 16'($urandom));
      put(12'h000, 16'h6010);
      put(12'h010, 16'hFFFF);
      do_reset();
      for (int n = 0; n < 500; n++) run_one();

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule